// File: doc/BRIEF.md
# Masked Byte Dot-Product Accumulate Unit

This unit is a SIMD integer datapath for quantised inference kernels. It treats each 32-bit lane of a wide vector as an accumulator. For every lane it takes four bytes from an unsigned source vector and the four matching bytes from a signed source vector, and forms their four products. It adds the sum of those products to the lane's previous accumulator value. Per-lane masking can either keep the old accumulator or clear it. A broadcast option repeats the lowest dword of the signed source across all lanes. The vector-length select picks 4, 8 or 16 active lanes, and every lane above that length reads as zero.

An operation is presented with a single-cycle `in_valid` pulse. The result is registered and appears one clock later together with a one-cycle `out_valid`. Operations may be issued back to back, one per cycle.

A two-state controller sequences the output. ST_IDLE is entered at reset, and no result is pending in it. The transition `issue` (in_valid high) moves it to ST_EMIT, where `out_valid` is high. From ST_EMIT, the transition `chain` (in_valid high) stays in ST_EMIT, and the transition `drain` (in_valid low) returns to ST_IDLE.

Top module: `dpa_unit`

## Requirements
- R1: Result lane i equals acc_in lane i plus the sum, over k = 0..3, of zero-extended byte src_u[32i+8k +: 8] times sign-extended byte src_s[32i+8k +: 8]. Lanes read only the accumulator values from before the operation.
- R2: The lane addition wraps modulo 2^32 with no saturation. With 0xFF against 0x80 in all four byte pairs and an accumulator of 0x7FFFFFFF, the lane gives 0x7FFE01FF. With 0xFF against 0x7F, it gives 0x8001FA03.
- R3: vlen_sel selects the active lane count: code 0 gives 4 lanes (128 bits), code 1 gives 8 lanes, and codes 2 and 3 give 16 lanes.
- R4: Every result bit at or above 32 times the active lane count is zero.
- R5: When mask_en is 1, zero_mode is 0 and wmask[i] is 0, active lane i returns its acc_in value unchanged.
- R6: When mask_en is 1, zero_mode is 1 and wmask[i] is 0, active lane i returns zero.
- R7: When mask_en is 0, every active lane is computed whatever wmask holds.
- R8: When bcast is 1, every lane uses src_s[31:0] as its signed bytes instead of its own dword.
- R9: Bits of wmask at or above the active lane count have no effect on the result.
- R10: After each cycle with in_valid high, out_valid is high for the next cycle and acc_out holds that operation's result. After a cycle with in_valid low, out_valid is low and acc_out keeps its value.
- R11: During and right after reset, out_valid is 0 and acc_out is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands valid; sampled on the rising edge |
| vlen_sel | input | 2 | Vector length code (0: 128, 1: 256, 2/3: 512 bits) |
| mask_en | input | 1 | Enables per-lane masking |
| zero_mode | input | 1 | 1: masked lanes cleared, 0: masked lanes keep accumulator |
| bcast | input | 1 | Broadcast src_s[31:0] to every lane |
| wmask | input | 16 | Per-lane write mask |
| acc_in | input | 512 | Accumulator vector |
| src_u | input | 512 | Unsigned byte source |
| src_s | input | 512 | Signed byte source |
| out_valid | output | 1 | Result valid, one cycle per operation |
| acc_out | output | 512 | Registered result vector |

## Verification
Several properties are checked on every cycle: the one-cycle valid timing, the hold of the result between operations, zero fill above the vector length, and both masking modes per lane. The arithmetic itself can only be shown by the bench's scenarios, which compare against an independent model. These scenarios cover the mixed-sign products, modular wrap, broadcast selection, disabled masking and ignored high mask bits, using random and directed operands.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
    localparam int LANE_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int PAIRS     = LANE_W / BYTE_W;
    localparam int MAX_LANES = 16;
    localparam int VEC_W     = LANE_W * MAX_LANES;

    typedef enum logic [1:0] {
        VL_128  = 2'd0,
        VL_256  = 2'd1,
        VL_512  = 2'd2,
        VL_512B = 2'd3
    } vlen_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_e;

    function automatic int lanes_for(input logic [1:0] code);
        unique case (code)
            VL_128:  return 4;
            VL_256:  return 8;
            default: return 16;
        endcase
    endfunction
endpackage

// File: rtl/dpa_lane.sv
module dpa_lane #(
    parameter int LW = 32,
    parameter int BW = 8,
    localparam int NP = LW / BW,
    localparam int PW = 2 * BW + 1
) (
    input  logic [LW-1:0] acc,
    input  logic [LW-1:0] uvec,
    input  logic [LW-1:0] svec,
    output logic [LW-1:0] sum
);
    logic signed [PW-1:0] prod [NP];

    for (genvar k = 0; k < NP; k++) begin : g_pair
        always_comb prod[k] = $signed({1'b0, uvec[k*BW +: BW]}) * $signed(svec[k*BW +: BW]);
    end

    always_comb begin
        sum = acc;
        for (int k = 0; k < NP; k++)
            sum = sum + {{(LW-PW){prod[k][PW-1]}}, prod[k]};
    end
endmodule

// File: rtl/dpa_ctrl.sv
module dpa_ctrl
    import dpa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic out_valid
);
    emit_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid) state_nx = ST_EMIT;
            ST_EMIT: if (!in_valid) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_EMIT: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
    end

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: rtl/dpa_unit.sv
module dpa_unit
    import dpa_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       vlen_sel,
    input  logic             mask_en,
    input  logic             zero_mode,
    input  logic             bcast,
    input  logic [15:0]      wmask,
    input  logic [VEC_W-1:0] acc_in,
    input  logic [VEC_W-1:0] src_u,
    input  logic [VEC_W-1:0] src_s,
    output logic             out_valid,
    output logic [VEC_W-1:0] acc_out
);
    logic [MAX_LANES-1:0] lane_on;
    logic [VEC_W-1:0]     res_d;
    logic [VEC_W-1:0]     res_q;

    dpa_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_valid (out_valid)
    );

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
        logic [LANE_W-1:0] s_pick;
        logic [LANE_W-1:0] dot;

        always_comb lane_on[i] = (i < lanes_for(vlen_sel));
        always_comb s_pick = bcast ? src_s[LANE_W-1:0] : src_s[i*LANE_W +: LANE_W];

        dpa_lane #(.LW(LANE_W), .BW(BYTE_W)) u_lane (
            .acc  (acc_in[i*LANE_W +: LANE_W]),
            .uvec (src_u[i*LANE_W +: LANE_W]),
            .svec (s_pick),
            .sum  (dot)
        );

        always_comb begin
            if (!lane_on[i])
                res_d[i*LANE_W +: LANE_W] = '0;
            else if (mask_en && !wmask[i])
                res_d[i*LANE_W +: LANE_W] = zero_mode ? '0 : acc_in[i*LANE_W +: LANE_W];
            else
                res_d[i*LANE_W +: LANE_W] = dot;
        end

        a_r6_zero_masked: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && lane_on[i] && mask_en && !wmask[i] && zero_mode)
            |=> acc_out[i*LANE_W +: LANE_W] == '0);
        a_r5_merge_masked: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && lane_on[i] && mask_en && !wmask[i] && !zero_mode)
            |=> acc_out[i*LANE_W +: LANE_W] == $past(acc_in[i*LANE_W +: LANE_W]));
        a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !lane_on[i]) |=> acc_out[i*LANE_W +: LANE_W] == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        res_q <= '0;
        else if (in_valid) res_q <= res_d;
    end

    assign acc_out = res_q;

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(acc_out));
    a_r3_min_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lane_on) >= 4);
endmodule

// File: tb/tb_dpa_unit.sv
`timescale 1ns/1ps
module tb_dpa_unit;
    localparam int VW = 512;

    logic clk = 0, rst_n = 0, in_valid = 0, mask_en = 0, zero_mode = 0, bcast = 0;
    logic [1:0] vlen_sel = 0;
    logic [15:0] wmask = 0;
    logic [VW-1:0] acc_in = 0, src_u = 0, src_s = 0, acc_out;
    logic out_valid;
    int total = 0, bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dpa_unit dut (.clk, .rst_n, .in_valid, .vlen_sel, .mask_en, .zero_mode, .bcast,
                  .wmask, .acc_in, .src_u, .src_s, .out_valid, .acc_out);

    function automatic logic [VW-1:0] model(input logic [1:0] vl, input logic me, input logic zm,
            input logic bc, input logic [15:0] wm, input logic [VW-1:0] a,
            input logic [VW-1:0] u, input logic [VW-1:0] s);
        logic [VW-1:0] r = '0;
        int n = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
        for (int i = 0; i < n; i++) begin
            int acc = a[i*32 +: 32];
            logic [31:0] sw = bc ? s[31:0] : s[i*32 +: 32];
            if (me && !wm[i]) r[i*32 +: 32] = zm ? 32'd0 : a[i*32 +: 32];
            else begin
                for (int k = 0; k < 4; k++)
                    acc += int'(u[i*32+8*k +: 8]) * int'($signed(sw[8*k +: 8]));
                r[i*32 +: 32] = acc;
            end
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [VW-1:0] exp);
        logic [VW-1:0] got;
        @(negedge clk); in_valid = 1;
        @(negedge clk); in_valid = 0;
        chk(out_valid === 1'b1, {req, " R10 valid"}, {511'd0, out_valid}, 512'd1);
        chk(acc_out === exp, req, acc_out, exp);
        got = acc_out;
        @(negedge clk);
        chk(out_valid === 1'b0 && acc_out === got, {req, " R10 hold"}, acc_out, got);
    endtask

    function automatic logic [VW-1:0] rnd512();
        logic [VW-1:0] v;
        for (int j = 0; j < 16; j++) v[j*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic set_op(input logic [1:0] vl, input logic me, input logic zm, input logic bc, input logic [15:0] wm);
        vlen_sel = vl; mask_en = me; zero_mode = zm; bcast = bc; wmask = wm;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] e, e2;
        void'($urandom(32'h5EED_0042));
        #5;
        chk(out_valid === 1'b0 && acc_out === '0, "R11 in reset", acc_out, '0);
        @(negedge clk); @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk(out_valid === 1'b0 && acc_out === '0, "R11 after reset", acc_out, '0);

        // R2 wrap corners on lane 0 with 128-bit length
        set_op(2'd0, 0, 0, 0, 16'h0);
        acc_in = '0; acc_in[31:0] = 32'h7FFF_FFFF;
        src_u = '0; src_u[31:0] = 32'hFFFF_FFFF;
        src_s = '0; src_s[31:0] = 32'h8080_8080;
        e = '0; e[31:0] = 32'h7FFE_01FF; e[127:32] = acc_in[127:32];
        run_op("R2 neg wrap", e);
        src_s[31:0] = 32'h7F7F_7F7F;
        e[31:0] = 32'h8001_FA03;
        run_op("R2 pos wrap", e);

        // R1 R3 R4: each length with full operands
        for (int v = 0; v < 4; v++) begin
            acc_in = rnd512(); src_u = rnd512(); src_s = rnd512();
            set_op(v[1:0], 0, 0, 0, 16'h0);
            run_op("R1 R3 R4 length", model(v[1:0], 0, 0, 0, 16'h0, acc_in, src_u, src_s));
        end

        // R5 merge, R6 zero
        acc_in = rnd512(); src_u = rnd512(); src_s = rnd512();
        set_op(2'd2, 1, 0, 0, 16'hA5C3);
        run_op("R5 merge", model(2'd2, 1, 0, 0, 16'hA5C3, acc_in, src_u, src_s));
        set_op(2'd2, 1, 1, 0, 16'hA5C3);
        run_op("R6 zero", model(2'd2, 1, 1, 0, 16'hA5C3, acc_in, src_u, src_s));

        // R7 mask disabled: result equals unmasked model
        set_op(2'd1, 0, 1, 0, 16'h0000);
        run_op("R7 mask off", model(2'd1, 0, 0, 0, 16'hFFFF, acc_in, src_u, src_s));

        // R8 broadcast
        set_op(2'd2, 0, 0, 1, 16'h0);
        e = model(2'd2, 0, 0, 0, 16'h0, acc_in, src_u, {16{src_s[31:0]}});
        run_op("R8 bcast", e);

        // R9 high mask bits ignored at 128 bits
        set_op(2'd0, 1, 1, 0, 16'h000F);
        e = model(2'd0, 0, 0, 0, 16'h0, acc_in, src_u, src_s);
        run_op("R9 low set", e);
        set_op(2'd0, 1, 1, 0, 16'hFFFF);
        run_op("R9 high set", e);

        // R10 back-to-back issue
        set_op(2'd1, 0, 0, 0, 16'h0);
        e = model(2'd1, 0, 0, 0, 16'h0, acc_in, src_u, src_s);
        @(negedge clk); in_valid = 1;
        @(negedge clk);
        chk(out_valid === 1'b1 && acc_out === e, "R10 chain first", acc_out, e);
        acc_in = rnd512();
        e2 = model(2'd1, 0, 0, 0, 16'h0, acc_in, src_u, src_s);
        @(negedge clk); in_valid = 0;
        chk(out_valid === 1'b1 && acc_out === e2, "R10 chain second", acc_out, e2);
        @(negedge clk);
        chk(out_valid === 1'b0, "R10 drain", {511'd0, out_valid}, '0);

        // random mix
        for (int t = 0; t < 150; t++) begin
            logic [1:0] vl = 2'($urandom);
            logic me = 1'($urandom), zm = 1'($urandom), bc = 1'($urandom);
            logic [15:0] wm = 16'($urandom);
            acc_in = rnd512(); src_u = rnd512(); src_s = rnd512();
            if (t % 10 == 0) begin src_u = '1; src_s = {64{8'h80}}; end
            set_op(vl, me, zm, bc, wm);
            run_op("R1 R5 R6 R8 random", model(vl, me, zm, bc, wm, acc_in, src_u, src_s));
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule